// File: doc/BRIEF.md
# Split Instruction/Data Cache Request Dispatcher

This block sits between a processor request queue and the coherence controller of a first-level cache that keeps separate instruction and data arrays. Each cycle it looks at the request at the head of the queue (load, instruction fetch, store or atomic, together with a line address), the presence of that line in each of the two arrays, whether the target array's set still has a free way, and the victim line that array would give up. From these it chooses one event for the controller, the line it applies to, and the array it targets.

Fetches go to the instruction array and every data access to the data array. A line may live in only one of the two arrays, so a line found in the wrong array is evicted from there first. A full set makes the dispatcher evict the victim line instead of starting the request. In both eviction cases the request stays in the queue and comes back on a later cycle. Requests whose type is unknown are dropped and flagged. All outputs are registered, so a decision appears one clock after the request is seen.

Top module: `req_dispatch`

## Requirements
- R1: While reset is asserted, and right after it, evValid, evKind, evCache, evLine, reqPop and badKind are all zero.
- R2: Request kinds are encoded 0 load, 1 fetch, 2 store, 3 atomic. A request event carries evKind 0 for load, 1 for fetch and 2 for both store and atomic.
- R3: The target array is the instruction array (evCache = 1) for a fetch and the data array (evCache = 0) for load, store and atomic.
- R4: When the line is present in the target array, the clock edge after the request produces the request event for the requested line in the target array with reqPop = 1, regardless of the free-way signal.
- R5: When the line is absent from the target array but present in the other one, the output is an eviction (evKind = 3) of the requested line in the other array with reqPop = 0; this wins over a full set.
- R6: When the line is in neither array and the target set has a free way, the request event is issued for the requested line with reqPop = 1.
- R7: When the line is in neither array and the target set is full, the output is an eviction of the supplied victim line in the target array with reqPop = 0.
- R8: A request kind above 3 produces no event, raises badKind for one cycle and pops the request.
- R9: With no valid request, evValid, reqPop and badKind are zero; whenever evValid is zero, evKind, evCache and evLine are zero.
- R10: A valid request never sees its line present in both arrays at once; this is checked as an assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is at the head of the queue |
| reqKind | input | 3 | Request kind (0 load, 1 fetch, 2 store, 3 atomic) |
| reqLine | input | LINE_W | Line address of the request |
| iPresent | input | 1 | Requested line is present in the instruction array |
| dPresent | input | 1 | Requested line is present in the data array |
| setRoom | input | 1 | Target array's set has a free way |
| victimLine | input | LINE_W | Line the target array would replace |
| evValid | output | 1 | An event is presented this cycle |
| evKind | output | 2 | Event: 0 load, 1 fetch, 2 store, 3 eviction |
| evLine | output | LINE_W | Line the event applies to |
| evCache | output | 1 | Array targeted: 1 instruction, 0 data |
| reqPop | output | 1 | Remove the request from the queue |
| badKind | output | 1 | Request kind was not recognised |

## Verification
The hardest case to reach from the ports is the one where a wrong-array eviction and a full-set eviction both apply, because only the ordering between them separates a correct design from one that evicts the victim first. The stimulus table drives it directly by marking the line present in the other array while holding the free-way signal low, and checks that the requested line, not the victim, is evicted from the other array. A store hit with a full set and a mid-request reset round out the ordering and reset cases.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [1:0] {
    EV_LOAD  = 2'd0,
    EV_FETCH = 2'd1,
    EV_STORE = 2'd2,
    EV_EVICT = 2'd3
  } evKind_e;

  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] K_LOAD   = 3'd0;
  localparam logic [KIND_W-1:0] K_FETCH  = 3'd1;
  localparam logic [KIND_W-1:0] K_STORE  = 3'd2;
  localparam logic [KIND_W-1:0] K_ATOMIC = 3'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic    fire;       // present an event
    logic    useVictim;  // take the victim line instead of the request line
    logic    toInstr;    // event targets the instruction array
    logic    pop;        // dequeue the request
    logic    bad;        // unknown request kind
    evKind_e kind;
  } strobe_t;

endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              iPresent,
  input  logic              dPresent,
  input  logic              setRoom,
  output strobe_t           st
);

  logic    kindOk;
  logic    fetchSide;
  evKind_e reqEvent;
  logic    targetHit;
  logic    otherHit;

  always_comb begin
    kindOk    = 1'b1;
    fetchSide = 1'b0;
    reqEvent  = EV_LOAD;
    unique case (reqKind)
      K_LOAD:             reqEvent = EV_LOAD;
      K_FETCH:  begin     reqEvent = EV_FETCH; fetchSide = 1'b1; end
      K_STORE, K_ATOMIC:  reqEvent = EV_STORE;
      default:            kindOk   = 1'b0;
    endcase
  end

  assign targetHit = fetchSide ? iPresent : dPresent;
  assign otherHit  = fetchSide ? dPresent : iPresent;

  always_comb begin
    st = '0;
    if (reqValid) begin
      if (!kindOk) begin
        st.bad = 1'b1;
        st.pop = 1'b1;
      end else if (targetHit) begin
        st.fire    = 1'b1;
        st.kind    = reqEvent;
        st.toInstr = fetchSide;
        st.pop     = 1'b1;
      end else if (otherHit) begin
        // line sits in the wrong array: push it out first
        st.fire    = 1'b1;
        st.kind    = EV_EVICT;
        st.toInstr = !fetchSide;
      end else if (setRoom) begin
        st.fire    = 1'b1;
        st.kind    = reqEvent;
        st.toInstr = fetchSide;
        st.pop     = 1'b1;
      end else begin
        st.fire      = 1'b1;
        st.kind      = EV_EVICT;
        st.toInstr   = fetchSide;
        st.useVictim = 1'b1;
      end
    end
  end

endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [LINE_W-1:0] victimLine,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [LINE_W-1:0] evLine,
  output logic              evCache,
  output logic              reqPop,
  output logic              badKind
);

  logic [LINE_W-1:0] lineNext;

  assign lineNext = st.useVictim ? victimLine : reqLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evValid <= 1'b0;
      evKind  <= '0;
      evLine  <= '0;
      evCache <= 1'b0;
      reqPop  <= 1'b0;
      badKind <= 1'b0;
    end else begin
      evValid <= st.fire;
      evKind  <= st.fire ? st.kind : 2'd0;
      evLine  <= st.fire ? lineNext : '0;
      evCache <= st.fire & st.toInstr;
      reqPop  <= st.pop;
      badKind <= st.bad;
    end
  end

endmodule

// File: rtl/req_dispatch.sv
module req_dispatch
  import disp_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              iPresent,
  input  logic              dPresent,
  input  logic              setRoom,
  input  logic [LINE_W-1:0] victimLine,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [LINE_W-1:0] evLine,
  output logic              evCache,
  output logic              reqPop,
  output logic              badKind
);

  strobe_t st;

  disp_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .iPresent (iPresent),
    .dPresent (dPresent),
    .setRoom  (setRoom),
    .st       (st)
  );

  disp_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .reqLine    (reqLine),
    .victimLine (victimLine),
    .evValid    (evValid),
    .evKind     (evKind),
    .evLine     (evLine),
    .evCache    (evCache),
    .reqPop     (reqPop),
    .badKind    (badKind)
  );

endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqKind,
  input logic [LINE_W-1:0] reqLine,
  input logic              iPresent,
  input logic              dPresent,
  input logic              setRoom,
  input logic [LINE_W-1:0] victimLine,
  input logic              evValid,
  input logic [1:0]        evKind,
  input logic [LINE_W-1:0] evLine,
  input logic              evCache,
  input logic              reqPop,
  input logic              badKind
);

  logic isFetch, kindOk, tgtHit, othHit;
  assign isFetch = (reqKind == 3'd1);
  assign kindOk  = (reqKind <= 3'd3);
  assign tgtHit  = isFetch ? iPresent : dPresent;
  assign othHit  = isFetch ? dPresent : iPresent;

  // R4: hit in target gives a popped request event for the same line
  a_r4_hit_issues: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && kindOk && tgtHit |=> evValid && evKind != 2'd3 && reqPop
                                     && evLine == $past(reqLine));

  // R5: wrong-array line is evicted from the other array, not popped
  a_r5_wrong_array: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && kindOk && !tgtHit && othHit |=> evValid && evKind == 2'd3
      && !reqPop && evLine == $past(reqLine) && evCache == !$past(isFetch));

  // R7: full set evicts the victim
  a_r7_victim: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && kindOk && !iPresent && !dPresent && !setRoom |=>
      evKind == 2'd3 && evLine == $past(victimLine) && !reqPop);

  // R8: unknown kind is dropped and flagged
  a_r8_bad_kind: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !kindOk |=> !evValid && badKind && reqPop);

  // R9: idle queue yields nothing
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !evValid && !reqPop && !badKind);

  // R10: a line never resides in both arrays
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !(iPresent && dPresent));

endmodule

bind req_dispatch disp_checker #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/test_req_dispatch.sv
`timescale 1ns/1ps
module test_req_dispatch;

  localparam int LW = 16;
  localparam logic [LW-1:0] L = 16'h1234;
  localparam logic [LW-1:0] V = 16'hBEEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqKind = '0;
  logic [LW-1:0] reqLine = '0;
  logic iPresent = 1'b0, dPresent = 1'b0, setRoom = 1'b0;
  logic [LW-1:0] victimLine = '0;
  logic evValid, evCache, reqPop, badKind;
  logic [1:0] evKind;
  logic [LW-1:0] evLine;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  req_dispatch #(.LINE_W(LW)) i_req_dispatch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqLine(reqLine), .iPresent(iPresent), .dPresent(dPresent),
    .setRoom(setRoom), .victimLine(victimLine), .evValid(evValid),
    .evKind(evKind), .evLine(evLine), .evCache(evCache),
    .reqPop(reqPop), .badKind(badKind)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] k;
    logic       iH, dH, rm;
    logic       eV;
    logic [1:0] eK;
    logic       eC;
    logic       eVic;
    logic       eP;
    logic       eB;
  } vec_t;

  localparam int N = 13;
  // v k iH dH rm | eV eK eC eVic eP eB
  localparam vec_t TBL [N] = '{
    '{1'b1,3'd0,1'b0,1'b1,1'b1, 1'b1,2'd0,1'b0,1'b0,1'b1,1'b0}, // 0 R2 load hit
    '{1'b1,3'd1,1'b1,1'b0,1'b1, 1'b1,2'd1,1'b1,1'b0,1'b1,1'b0}, // 1 R3 fetch hit
    '{1'b1,3'd2,1'b0,1'b1,1'b1, 1'b1,2'd2,1'b0,1'b0,1'b1,1'b0}, // 2 R2 store hit
    '{1'b1,3'd3,1'b0,1'b1,1'b1, 1'b1,2'd2,1'b0,1'b0,1'b1,1'b0}, // 3 R2 atomic hit
    '{1'b1,3'd0,1'b1,1'b0,1'b0, 1'b1,2'd3,1'b1,1'b0,1'b0,1'b0}, // 4 R5 wrong array + full
    '{1'b1,3'd1,1'b0,1'b1,1'b1, 1'b1,2'd3,1'b0,1'b0,1'b0,1'b0}, // 5 R5 data line fetched
    '{1'b1,3'd2,1'b0,1'b0,1'b1, 1'b1,2'd2,1'b0,1'b0,1'b1,1'b0}, // 6 R6 store miss room
    '{1'b1,3'd1,1'b0,1'b0,1'b1, 1'b1,2'd1,1'b1,1'b0,1'b1,1'b0}, // 7 R6 fetch miss room
    '{1'b1,3'd0,1'b0,1'b0,1'b0, 1'b1,2'd3,1'b0,1'b1,1'b0,1'b0}, // 8 R7 load full set
    '{1'b1,3'd1,1'b0,1'b0,1'b0, 1'b1,2'd3,1'b1,1'b1,1'b0,1'b0}, // 9 R7 fetch full set
    '{1'b1,3'd5,1'b0,1'b1,1'b1, 1'b0,2'd0,1'b0,1'b0,1'b1,1'b1}, // 10 R8 bad kind
    '{1'b0,3'd0,1'b0,1'b1,1'b1, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // 11 R9 idle
    '{1'b1,3'd3,1'b0,1'b1,1'b0, 1'b1,2'd2,1'b0,1'b0,1'b1,1'b0}  // 12 R4 hit, full set
  };

  function automatic string tagOf(input int i);
    case (i)
      0, 2, 3: tagOf = "R2";
      1:       tagOf = "R3";
      4, 5:    tagOf = "R5";
      6, 7:    tagOf = "R6";
      8, 9:    tagOf = "R7";
      10:      tagOf = "R8";
      11:      tagOf = "R9";
      default: tagOf = "R4";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic eV, input logic [1:0] eK,
                          input logic eC, input logic [LW-1:0] eL,
                          input logic eP, input logic eB);
    compared++;
    if (evValid !== eV || evKind !== eK || evCache !== eC || evLine !== eL ||
        reqPop !== eP || badKind !== eB) begin
      mismatched++;
      $display("FAIL %s: got v=%b k=%0d c=%b l=%h p=%b b=%b, want v=%b k=%0d c=%b l=%h p=%b b=%b",
               tag, evValid, evKind, evCache, evLine, reqPop, badKind,
               eV, eK, eC, eL, eP, eB);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    reqLine = L;
    victimLine = V;
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 2'd0, 1'b0, '0, 1'b0, 1'b0); // R1 in reset
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, 2'd0, 1'b0, '0, 1'b0, 1'b0); // R1 after release

    for (int i = 0; i < N; i++) begin
      reqValid = TBL[i].v;
      reqKind  = TBL[i].k;
      iPresent = TBL[i].iH;
      dPresent = TBL[i].dH;
      setRoom  = TBL[i].rm;
      @(negedge clk);
      checkOut(tagOf(i), TBL[i].eV, TBL[i].eK, TBL[i].eC,
               TBL[i].eV ? (TBL[i].eVic ? V : L) : '0, TBL[i].eP, TBL[i].eB);
    end

    // R5 with a different line and victim: requested line wins over victim
    reqLine = 16'h0F0F; victimLine = 16'hAAAA;
    reqValid = 1'b1; reqKind = 3'd2; iPresent = 1'b1; dPresent = 1'b0; setRoom = 1'b0;
    @(negedge clk);
    checkOut("R5", 1'b1, 2'd3, 1'b1, 16'h0F0F, 1'b0, 1'b0);

    // R8 then back to a hit: badKind lasts one cycle
    reqKind = 3'd7; iPresent = 1'b0; dPresent = 1'b1;
    @(negedge clk);
    checkOut("R8", 1'b0, 2'd0, 1'b0, '0, 1'b1, 1'b1);
    reqKind = 3'd0;
    @(negedge clk);
    checkOut("R8", 1'b1, 2'd0, 1'b0, 16'h0F0F, 1'b1, 1'b0);

    // R1 reset asserted with a live request
    rstN = 1'b0;
    #1;
    checkOut("R1", 1'b0, 2'd0, 1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R9", 1'b0, 2'd0, 1'b0, '0, 1'b0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule